// File: doc/BRIEF.md
# Banked Data RAM Window Controller

This block sits in front of the low end of a byte-wide data space. Data addresses 00h–3Fh form a 64-byte window. A bus access in that window goes either to a base RAM or to one of several physical 64-byte page RAMs. The CPU uses the same window addresses in every case, so the selected page looks as if it were bank 0.

A bank-select byte chooses the page. It is mapped at data address CBh and can only be written. Each page has its own select bit: bit 3 enables page 1 and bit 4 enables page 2. When no page bit is set, the window maps to the base RAM. Setting several page bits is an error condition. The block does not resolve it by priority. All matching pages are enabled together: a write lands in each of them, and a read returns the bitwise OR of their data. A flag output reports this error condition.

The select byte has no reset term, so a reset does not change the page it holds. Reads have one cycle of latency. The read data bus is zero in any cycle that carries no window read result.

Top module: `bank_window_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `bus_rdata` is 00h.
- R2: A write to address CBh loads only bits 3 and 4 of the write data into the select byte. Bit 3 enables page 1 and bit 4 enables page 2. All other bits of the write data are ignored.
- R3: A read of address CBh, or of any address outside 00h–3Fh, returns 00h in the following cycle.
- R4: With select value 00h, a window access goes to the base RAM. The base RAM keeps its data while pages are selected.
- R5: With select value 08h, window accesses reach page 1. With 10h, they reach page 2. The two pages, and the base RAM, hold separate bytes at the same window address.
- R6: The data for a window read strobed in cycle N appears on `bus_rdata` in cycle N+1. In a cycle after no read, `bus_rdata` is 00h.
- R7: A select write in cycle N applies to a window access that starts in cycle N+1.
- R8: With both page bits set, `multi_sel` is 1. A window write stores the byte in both pages, and a window read returns the OR of the two pages' bytes. With one page bit set or none, `multi_sel` is 0.
- R9: Reset does not change the select byte. After a reset, window accesses go to the page that was selected before the reset.
- R10: A write to an address from 40h to FFh other than CBh changes no RAM byte and no select bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the read data path only |
| bus_addr | input | 8 | Data-space address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| page_en | output | 2 | Page enables currently decoded from the select byte |
| multi_sel | output | 1 | More than one page bit is set |

## Verification
A wrong select byte sends a window access to the wrong store. The fault shows up on `bus_rdata` in the cycle after the first read that follows, because each store holds its own pattern at a shared address. A select write that applies one cycle late, or that picks up a stray bit, shows up on the read that immediately follows a back-to-back sequence. An address decode that leaks writes from outside the window shows up when the aliased window byte is read back. A select byte that reset clears shows up on the first read after reset, which returns the base byte instead of the page byte.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

   // Result of decoding one bus address
   typedef struct packed {
      logic win;   // address falls inside the banked window
      logic sel;   // address is the bank-select byte
   } bwc_hit_t;

   // Population count for enable vectors of any practical width
   function automatic int unsigned bwc_popcount(input logic [31:0] v, input int unsigned n);
      int unsigned c;
      c = 0;
      for (int unsigned i = 0; i < n; i++) begin
         if (v[i]) c++;
      end
      return c;
   endfunction

endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
   import bwc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned WIN_DEPTH = 64,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hCB
) (
   input  logic [ADDR_W-1:0] addr,
   output bwc_hit_t          hit
);
   localparam int unsigned WIN_AW = $clog2(WIN_DEPTH);

   initial begin
      assert (WIN_DEPTH == (1 << WIN_AW)) else $error("WIN_DEPTH must be a power of two");
      assert (WIN_AW < ADDR_W) else $error("window must be smaller than address space");
      assert (SEL_ADDR >= WIN_DEPTH) else $error("select byte must lie outside the window");
   end

   always_comb begin
      hit.win = (addr[ADDR_W-1:WIN_AW] == '0);
      hit.sel = (addr == SEL_ADDR);
   end
endmodule

// File: rtl/bwc_sel_reg.sv
module bwc_sel_reg
   import bwc_pkg::*;
#(
   parameter int unsigned NUM_PAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_we,
   input  logic [NUM_PAGES-1:0] sel_d,
   output logic [NUM_PAGES-1:0] page_en,
   output logic                 multi_sel
);
   initial begin
      assert (NUM_PAGES >= 1 && NUM_PAGES <= 32) else $error("NUM_PAGES out of range");
   end

   logic [NUM_PAGES-1:0] sel_q;

   // Deliberately no reset term: content survives reset
   always_ff @(posedge clk) begin
      if (sel_we) sel_q <= sel_d;
   end

   assign page_en   = sel_q;
   assign multi_sel = (bwc_popcount(32'(sel_q), NUM_PAGES) > 1);

   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (sel_q == $past(sel_d)));                    // R2
   AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> $stable(sel_q));                             // R10
endmodule

// File: rtl/bwc_ram.sv
module bwc_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   // Output register returns zero when not read so the top can OR outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[addr];
      else         rdata <= '0;
   end

   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> (rdata == '0));                                  // R6
endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
   import bwc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WIN_DEPTH = 64,
   parameter int unsigned NUM_PAGES = 2,
   parameter int unsigned SEL_LSB   = 3,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hCB
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_PAGES-1:0] page_en,
   output logic                 multi_sel
);
   localparam int unsigned WIN_AW = $clog2(WIN_DEPTH);

   initial begin
      assert (SEL_LSB + NUM_PAGES <= DATA_W) else $error("select bits exceed data width");
   end

   bwc_hit_t          hit;
   logic [WIN_AW-1:0] win_addr;
   logic              base_we, base_re;
   logic [NUM_PAGES-1:0] pg_we, pg_re;
   logic [DATA_W-1:0] base_rdata;
   logic [DATA_W-1:0] pg_rdata [NUM_PAGES];
   logic [DATA_W-1:0] pg_or;

   bwc_decode #(.ADDR_W(ADDR_W), .WIN_DEPTH(WIN_DEPTH), .SEL_ADDR(SEL_ADDR)) u_decode (
      .addr (bus_addr),
      .hit  (hit)
   );

   bwc_sel_reg #(.NUM_PAGES(NUM_PAGES)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (bus_wr && hit.sel),
      .sel_d     (bus_wdata[SEL_LSB +: NUM_PAGES]),
      .page_en   (page_en),
      .multi_sel (multi_sel)
   );

   assign win_addr = bus_addr[WIN_AW-1:0];
   assign base_we  = bus_wr && hit.win && (page_en == '0);
   assign base_re  = bus_rd && hit.win && (page_en == '0);
   assign pg_we    = {NUM_PAGES{bus_wr && hit.win}} & page_en;
   assign pg_re    = {NUM_PAGES{bus_rd && hit.win}} & page_en;

   bwc_ram #(.DATA_W(DATA_W), .DEPTH(WIN_DEPTH)) u_base (
      .clk (clk), .rst_n (rst_n), .we (base_we), .re (base_re),
      .addr (win_addr), .wdata (bus_wdata), .rdata (base_rdata)
   );

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      bwc_ram #(.DATA_W(DATA_W), .DEPTH(WIN_DEPTH)) u_page (
         .clk (clk), .rst_n (rst_n), .we (pg_we[p]), .re (pg_re[p]),
         .addr (win_addr), .wdata (bus_wdata), .rdata (pg_rdata[p])
      );
   end

   // Several enabled pages merge as a wired OR
   always_comb begin
      pg_or = '0;
      for (int p = 0; p < NUM_PAGES; p++) pg_or = pg_or | pg_rdata[p];
   end

   assign bus_rdata = base_rdata | pg_or;

   AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit.win) |=> (bus_rdata == '0));             // R3
   AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));                          // R6
   AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      multi_sel |-> ($countones(page_en) > 1));                // R8
endmodule

// File: tb/bank_window_ctrl_tb.sv
module bank_window_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [1:0] page_en;
   logic       multi_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bank_window_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
      .page_en (page_en), .multi_sel (multi_sel)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // Each bus task spans one cycle, negedge to negedge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      repeat (2) @(negedge clk);
      check("R1 rdata in reset", bus_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata after reset", bus_rdata, 8'h00);
   endtask

   task automatic t_base_and_pages();
      logic [7:0] d;
      wr(8'hCB, 8'h00);
      wr(8'h05, 8'h55);
      wr(8'h07, 8'h70);
      rd(8'h05, d); check("R4 base read", d, 8'h55);
      wr(8'hCB, 8'h08); wr(8'h05, 8'h11);
      wr(8'hCB, 8'h10); wr(8'h05, 8'h22);
      rd(8'h05, d); check("R5 page2 read", d, 8'h22);
      wr(8'hCB, 8'h08);
      rd(8'h05, d); check("R5 page1 read", d, 8'h11);
      check("R8 flag low single page", {7'd0, multi_sel}, 8'h00);
      wr(8'hCB, 8'h00);
      rd(8'h05, d); check("R4 base kept", d, 8'h55);
   endtask

   task automatic t_latency_and_outside();
      logic [7:0] d;
      rd(8'h05, d); check("R6 data cycle after read", d, 8'h55);
      @(negedge clk);
      check("R6 zero after idle", bus_rdata, 8'h00);
      rd(8'hCB, d); check("R3 select not readable", d, 8'h00);
      rd(8'h85, d); check("R3 outside window", d, 8'h00);
   endtask

   task automatic t_ignored_bits();
      logic [7:0] d;
      wr(8'hCB, 8'hEF);
      check("R2 page_en from EFh", {6'd0, page_en}, 8'h01);
      rd(8'h05, d); check("R2 EFh reaches page1", d, 8'h11);
      wr(8'hCB, 8'hF7);
      rd(8'h05, d); check("R2 F7h reaches page2", d, 8'h22);
   endtask

   task automatic t_back_to_back();
      logic [7:0] d;
      wr(8'hCB, 8'h08);
      wr(8'h07, 8'h77);
      wr(8'hCB, 8'h00);
      rd(8'h07, d); check("R7 next cycle uses base", d, 8'h70);
      wr(8'hCB, 8'h08);
      rd(8'h07, d); check("R7 next cycle uses page1", d, 8'h77);
   endtask

   task automatic t_outside_write();
      logic [7:0] d;
      wr(8'hCB, 8'h00);
      wr(8'h47, 8'hEE);
      wr(8'hC0, 8'h18);
      check("R10 select untouched", {7'd0, multi_sel}, 8'h00);
      rd(8'h07, d); check("R10 alias write ignored", d, 8'h70);
   endtask

   task automatic t_multi();
      logic [7:0] d;
      wr(8'hCB, 8'h18);
      check("R8 flag high", {7'd0, multi_sel}, 8'h01);
      rd(8'h05, d); check("R8 OR of pages", d, 8'h33);
      wr(8'h06, 8'hA5);
      wr(8'hCB, 8'h08);
      rd(8'h06, d); check("R8 write hit page1", d, 8'hA5);
      wr(8'hCB, 8'h10);
      rd(8'h06, d); check("R8 write hit page2", d, 8'hA5);
   endtask

   task automatic t_reset_keeps_sel();
      logic [7:0] d;
      wr(8'hCB, 8'h10);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h05, d); check("R9 page2 after reset", d, 8'h22);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_base_and_pages();
      t_latency_and_outside();
      t_ignored_bits();
      t_back_to_back();
      t_outside_write();
      t_multi();
      t_reset_keeps_sel();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule